// File: doc/BRIEF.md
# Timekeeping Write Gate and Second-Phase Realignment

This block stands between the host register bus and the timekeeping registers of a real-time clock. A lock bit in the interrupt control register comes out of reset cleared. While it is clear, the bus cannot change the time registers. Once the host sets it, byte writes to the time registers are staged. They are committed together only when the bus transaction closes with a STOP condition.

The block also holds the prescaler that divides the 32.768 kHz enable down to a one-second tick. The seconds tick stays off after reset. The first STOP that commits staged time data starts it. Every later committing STOP restarts it, and the divider is cleared at that STOP. The next second therefore begins exactly at the moment the host finished setting the time. A transaction that is abandoned with a fresh START, or that carries no accepted time write, does not realign the phase.

Top module: `rtc_wr_sync`

## Requirements
- R1: After synchronous reset, `wr_en`, `auto_clr`, `run`, `sec_tick` and every bit of `time_we` are 0.
- R2: While `wr_en` is 0, a strobe to a time register stages nothing. A following STOP gives no `time_we` pulse and neither starts nor realigns the tick.
- R3: A strobe to the control address (default 8) loads data bit 6 into `wr_en` and data bit 7 into `auto_clr` on the next clock. Every other data bit has no effect.
- R4: While `wr_en` is 1, a strobe to a time address below `N_TIME` stages the byte for that register, and the last write wins. One cycle after `bus_stop`, `time_we` pulses for one cycle with exactly the staged registers set, and `time_wdata` slice i carries the last byte for register i.
- R5: A `bus_start` discards all staged writes. A STOP that follows without new accepted writes produces no `time_we` and does not realign.
- R6: `run` stays 0 until the first STOP that commits at least one time register. From then on it stays 1 until reset.
- R7: The STOP of a committing transaction clears the prescaler. The first `sec_tick` is then seen one cycle after the 2^PRESC_W-th `tick_en` pulse that follows the STOP cycle.
- R8: While `run` is 1, `sec_tick` is a one-cycle pulse every 2^PRESC_W `tick_en` pulses. Cycles with `tick_en` low do not advance the count.
- R9: Strobes to addresses that are neither below `N_TIME` nor equal to the control address change nothing.
- R10: A committing STOP in the middle of a second discards the partial count, so the phase follows the latest committing STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse at the 32.768 kHz rate |
| wr_stb | input | 1 | Register write strobe from the bus |
| wr_addr | input | ADDR_W | Register address of the strobe |
| wr_data | input | DATA_W | Write byte |
| bus_start | input | 1 | START or repeated START detected |
| bus_stop | input | 1 | STOP detected |
| wr_en | output | 1 | Time-register write enable bit |
| auto_clr | output | 1 | Status auto-clear bit stored in the control register |
| time_we | output | N_TIME | Per-register commit pulse |
| time_wdata | output | N_TIME*DATA_W | Committed bytes, register i in slice i |
| sec_tick | output | 1 | One-second tick pulse |
| run | output | 1 | Seconds counting has been started |

## Verification
The divider is run with `tick_en` high in every cycle and with `tick_en` high one cycle in three. Both patterns must put the tick at the same count of enables, which shows that the block counts pulses and not clock cycles. Realignment is tried three ways: a STOP after locked writes, a STOP after an abort by START, and a committing STOP in the middle of a second. Only the last may move the phase. Staging is tried with repeated writes to one register and with writes to unused addresses, so the bench can tell last-write-wins apart from stray enables.

// File: rtl/rtc_wr_pkg.sv
// Package: shared constants for the timekeeping write gate.
// Assumes the control register is at least 8 bits wide.
package rtc_wr_pkg;
    localparam int unsigned WREN_BIT = 6;  // time-register write enable
    localparam int unsigned ACLR_BIT = 7;  // status auto-clear enable
endpackage

// File: rtl/rtc_ctrl_reg.sv
// Module: rtc_ctrl_reg
// Holds the two control bits this block owns: the time write enable and
// the status auto-clear. Writes to the control address take effect at the
// next clock and are not staged. Assumes DATA_W > ACLR_BIT.
module rtc_ctrl_reg
    import rtc_wr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CTRL_ADDR = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_en,
    output logic              auto_clr
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    logic hit;

    // Decode a strobe aimed at the control register.
    always_comb hit = wr_stb && (wr_addr == CTRL_A);

    // Load the two owned bits on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en    <= 1'b0;
            auto_clr <= 1'b0;
        end else if (hit) begin
            wr_en    <= wr_data[WREN_BIT];
            auto_clr <= wr_data[ACLR_BIT];
        end
    end

    p_locked_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!wr_en && !auto_clr));

    p_ctrl_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (wr_en == $past(wr_data[WREN_BIT])));
endmodule

// File: rtl/rtc_wr_stage.sv
// Module: rtc_wr_stage
// Stages accepted time-register bytes during a bus transaction and commits
// them at STOP. A START drops anything staged. STOP takes priority over a
// coincident strobe, which is then dropped. The combinational sync output
// marks a committing STOP.
module rtc_wr_stage #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned N_TIME = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_stb,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     bus_start,
    input  logic                     bus_stop,
    output logic [N_TIME-1:0]        time_we,
    output logic [N_TIME*DATA_W-1:0] time_wdata,
    output logic                     sync
);
    logic [N_TIME-1:0] pend;
    logic [N_TIME-1:0] take;

    // Committing STOP: at least one register is staged.
    always_comb sync = bus_stop && (|pend);

    for (genvar i = 0; i < N_TIME; i++) begin : g_slot
        logic [DATA_W-1:0] stage_q;

        // Accept a byte for this slot only while writes are unlocked.
        always_comb take[i] = wr_stb && wr_en && !bus_stop && !bus_start
                              && (wr_addr == ADDR_W'(i));

        // Staged byte for this slot; the last write wins.
        always_ff @(posedge clk) begin
            if (!rst_n)       stage_q <= '0;
            else if (take[i]) stage_q <= wr_data;
        end

        assign time_wdata[i*DATA_W +: DATA_W] = stage_q;
    end

    // Pending mask: set by accepted writes, cleared by START or STOP.
    always_ff @(posedge clk) begin
        if (!rst_n)                      pend <= '0;
        else if (bus_stop || bus_start)  pend <= '0;
        else                             pend <= pend | take;
    end

    // One-cycle commit pulse carrying the staged mask.
    always_ff @(posedge clk) begin
        if (!rst_n)        time_we <= '0;
        else if (bus_stop) time_we <= pend;
        else               time_we <= '0;
    end

    p_locked_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !wr_en && !bus_start && !bus_stop) |=> $stable(pend));

    p_commit_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|time_we) |-> $past(bus_stop));

    p_start_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && !bus_stop) |=> (pend == '0));
endmodule

// File: rtl/rtc_sec_prescaler.sv
// Module: rtc_sec_prescaler
// Divides the tick enable by 2^PRESC_W into a one-cycle seconds pulse.
// It is idle until the first sync. Every sync clears the divider, so the
// next pulse follows exactly 2^PRESC_W enables later. Assumes PRESC_W >= 1.
module rtc_sec_prescaler #(
    parameter int unsigned PRESC_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic sync,
    output logic sec_tick,
    output logic run
);
    localparam logic [PRESC_W-1:0] LAST = '1;

    logic [PRESC_W-1:0] cnt;

    // Run flag: set by the first committing STOP, held until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    run <= 1'b0;
        else if (sync) run <= 1'b1;
    end

    // Divider and tick: sync clears, enables advance while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            sec_tick <= 1'b0;
        end else if (sync) begin
            cnt      <= '0;
            sec_tick <= 1'b0;
        end else if (run && tick_en) begin
            cnt      <= cnt + 1'b1;
            sec_tick <= (cnt == LAST);
        end else begin
            sec_tick <= 1'b0;
        end
    end

    p_tick_needs_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> run);

    p_sync_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> ((cnt == '0) && !sec_tick));

    p_tick_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);
endmodule

// File: rtl/rtc_wr_sync.sv
// Module: rtc_wr_sync (top)
// Gates host writes to the timekeeping registers behind a control bit,
// commits staged bytes at bus STOP, and restarts the seconds prescaler on
// each committing STOP. Assumes the bus front end delivers START, STOP and
// strobe as one-cycle pulses in the clk domain.
module rtc_wr_sync #(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned N_TIME    = 7,
    parameter int unsigned CTRL_ADDR = 8,
    parameter int unsigned PRESC_W   = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_en,
    input  logic                     wr_stb,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     bus_start,
    input  logic                     bus_stop,
    output logic                     wr_en,
    output logic                     auto_clr,
    output logic [N_TIME-1:0]        time_we,
    output logic [N_TIME*DATA_W-1:0] time_wdata,
    output logic                     sec_tick,
    output logic                     run
);
    logic sync;

    rtc_ctrl_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_en(wr_en), .auto_clr(auto_clr)
    );

    rtc_wr_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_TIME(N_TIME)) u_stage (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .bus_start(bus_start),
        .bus_stop(bus_stop), .time_we(time_we), .time_wdata(time_wdata),
        .sync(sync)
    );

    rtc_sec_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sync(sync),
        .sec_tick(sec_tick), .run(run)
    );

    p_no_commit_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|time_we) |-> run);
endmodule

// File: tb/rtc_wr_sync_bench.sv
// Bench for rtc_wr_sync with a small configuration (8 enables per second).
module rtc_wr_sync_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4, DW = 8, NT = 4, CA = 8, PW = 3;
    localparam int SEC = 1 << PW;

    logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, wr_stb = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic bus_start = 1'b0, bus_stop = 1'b0;
    logic wr_en, auto_clr, sec_tick, run;
    logic [NT-1:0] time_we;
    logic [NT*DW-1:0] time_wdata;

    int checks = 0, errors = 0, cyc = 0;
    bit en_every = 1'b1;
    bit model_on = 1'b0;

    // Reference state built from the requirements.
    logic [NT-1:0] m_pend, m_we;
    logic [DW-1:0] m_data [NT];
    logic m_wren, m_aclr, m_run, m_tick;
    int   m_cnt;

    rtc_wr_sync #(.ADDR_W(AW), .DATA_W(DW), .N_TIME(NT), .CTRL_ADDR(CA), .PRESC_W(PW)) u_rtc_wr_sync (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .bus_start(bus_start),
        .bus_stop(bus_stop), .wr_en(wr_en), .auto_clr(auto_clr),
        .time_we(time_we), .time_wdata(time_wdata), .sec_tick(sec_tick), .run(run)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Reference model, advanced at each clock edge.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_pend <= '0; m_we <= '0; m_wren <= 0; m_aclr <= 0;
            m_run <= 0; m_tick <= 0; m_cnt <= 0;
            for (int i = 0; i < NT; i++) m_data[i] <= '0;
        end else begin
            m_we <= bus_stop ? m_pend : '0;
            if (bus_stop || bus_start) m_pend <= '0;
            else if (wr_stb && m_wren && int'(wr_addr) < NT) begin
                m_pend[wr_addr] <= 1'b1;
                m_data[wr_addr] <= wr_data;
            end
            if (wr_stb && int'(wr_addr) == CA) begin
                m_wren <= wr_data[6];
                m_aclr <= wr_data[7];
            end
            if (bus_stop && (|m_pend)) begin
                m_run <= 1; m_cnt <= 0; m_tick <= 0;
            end else if (m_run && tick_en) begin
                m_tick <= ((m_cnt % SEC) == SEC - 1);
                m_cnt  <= (m_cnt + 1) % SEC;
            end else m_tick <= 0;
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (model_on) begin
            chk(sec_tick == m_tick, "R8 tick", sec_tick, m_tick);
            chk(run == m_run, "R6 run", run, m_run);
            chk(time_we == m_we, "R4 commit mask", time_we, m_we);
            chk(wr_en == m_wren, "R3 wr_en", wr_en, m_wren);
            for (int i = 0; i < NT; i++)
                if (time_we[i])
                    chk(time_wdata[i*DW +: DW] == m_data[i], "R4 data", time_wdata[i*DW +: DW], m_data[i]);
        end
    end

    // Tick enable: every cycle, or one cycle in three.
    always @(negedge clk) tick_en <= en_every ? 1'b1 : (cyc % 3 == 0);

    task automatic wr(input int a, input int d);
        @(negedge clk); wr_stb = 1; wr_addr = AW'(a); wr_data = DW'(d);
        @(negedge clk); wr_stb = 0;
    endtask
    task automatic stop_pulse();
        @(negedge clk); bus_stop = 1;
        @(negedge clk); bus_stop = 0;
    endtask
    task automatic start_pulse();
        @(negedge clk); bus_start = 1;
        @(negedge clk); bus_start = 0;
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask
    // With tick_en held high, the first tick must be seen SEC+1 negedges after STOP.
    task automatic first_tick(input string req);
        chk(sec_tick == 1'b0, req, sec_tick, 0);
        for (int k = 2; k <= SEC + 1; k++) begin
            @(negedge clk);
            chk(sec_tick == (k == SEC + 1), req, sec_tick, k == SEC + 1);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 100000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1;
        // R1: reset state
        chk(!wr_en && !auto_clr, "R1 ctrl bits", {wr_en, auto_clr}, 0);
        chk(!run && !sec_tick && time_we == '0, "R1 outputs", {run, sec_tick, time_we}, 0);
        model_on = 1;
        // R2: locked write then STOP
        start_pulse(); wr(0, 8'h12); stop_pulse();
        chk(time_we == '0, "R2 no commit", time_we, 0);
        idle(2 * SEC);
        chk(!run && !sec_tick, "R2 not started", {run, sec_tick}, 0);
        // R3: control bit decoding
        wr(CA, 8'h40); chk(wr_en && !auto_clr, "R3 bit6", {wr_en, auto_clr}, 2);
        wr(CA, 8'h80); chk(!wr_en && auto_clr, "R3 bit7", {wr_en, auto_clr}, 1);
        wr(CA, 8'h3F); chk(!wr_en && !auto_clr, "R3 other bits", {wr_en, auto_clr}, 0);
        wr(CA, 8'hC0); chk(wr_en && auto_clr, "R3 both", {wr_en, auto_clr}, 3);
        // R4, R9: staging, last write wins, stray addresses
        start_pulse(); wr(1, 8'h5A); wr(3, 8'h11); wr(1, 8'hA5); wr(5, 8'hEE); wr(15, 8'hEE);
        stop_pulse();
        chk(time_we == 4'b1010, "R9 mask", time_we, 4'b1010);
        chk(time_wdata[1*DW +: DW] == 8'hA5, "R4 last wins", time_wdata[1*DW +: DW], 8'hA5);
        chk(time_wdata[3*DW +: DW] == 8'h11, "R4 data", time_wdata[3*DW +: DW], 8'h11);
        chk(run, "R6 started", run, 1);
        first_tick("R7 first tick");
        idle(4 * SEC);
        en_every = 0; idle(10 * SEC); en_every = 1;   // R8 sparse enables
        idle(3);
        // R5: abort by START, then STOP: no commit, no realign
        start_pulse(); wr(2, 8'h77); start_pulse(); stop_pulse();
        chk(time_we == '0, "R5 aborted", time_we, 0);
        idle(SEC + 3);
        // R10: committing STOP mid-second realigns
        start_pulse(); wr(0, 8'h33); stop_pulse();
        chk(time_we == 4'b0001, "R10 commit", time_we, 1);
        first_tick("R10 realign");
        // R2: relocked writes are ignored again
        wr(CA, 8'h00); start_pulse(); wr(2, 8'h99); stop_pulse();
        chk(time_we == '0, "R2 relocked", time_we, 0);
        idle(3 * SEC);
        model_on = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule